// File: doc/BRIEF.md
# MSI Capture Controller

This block receives message-signalled interrupts on the root-port side of a PCIe link. Inbound memory writes arrive on a valid/ready stream of address and data. When a write's full 64-bit address equals the programmed interrupt target address, its data word is taken as a global vector number. That vector selects one pending bit in one bank of 32 vectors. Each bank holds an enable word, a mask word and a status word. The status word collects pending events and software clears it by writing ones.

Software reaches the target address and the bank registers through a plain 32-bit register port with a 12-bit byte address. A single interrupt line to the host goes high whenever any bank has a pending bit whose mask bit is clear. The handler reads the status words and writes back the bits it has serviced. The number of banks is a parameter and defaults to 8, which gives 256 vectors.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, the target address, every enable word, every mask word and every status word read as zero, and `irq_out` is low.
- R2: The low 32 bits of the target address are read and written at byte offset 0x820, and the high 32 bits at 0x824.
- R3: An accepted inbound write with data n below 32 times the bank count sets status bit (n mod 32) of bank (n div 32). This happens only if the address equals the full 64-bit target and that bit's enable is 1. Otherwise the write leaves every status bit unchanged.
- R4: An inbound write whose data is at or above 32 times the bank count changes no status bit, even when the address matches.
- R5: The registers of bank i are spaced 12 bytes apart per bank: enable at 0x828 + 12*i, mask at 0x82C + 12*i and status at 0x830 + 12*i. A read returns its data on `reg_rdata` one cycle after `reg_rd_en`. An offset that matches no register reads as zero.
- R6: A write to a status word clears exactly the status bits that are 1 in the written data. All other bits keep their value.
- R7: If an inbound write sets a status bit in the same cycle that a software write clears that bit, the bit ends up set.
- R8: `irq_out` is the OR over all banks of (status AND NOT mask). It follows the register state in the cycle after the edge that changed that state.
- R9: `in_ready` is always high. The stream never applies back-pressure, and a write is accepted in every cycle that `in_valid` is high, including back-to-back cycles.
- R10: A mask bit only hides a vector from `irq_out`. A masked vector that is enabled is still recorded in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound memory write present |
| in_ready | output | 1 | Inbound write accepted (constant 1) |
| in_addr | input | 64 | Inbound write byte address |
| in_data | input | 32 | Inbound write data, carrying the vector number |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after the strobe |
| irq_out | output | 1 | Aggregated interrupt to the host |

## Verification
The capture path is swept over every one of the 256 vectors with all banks enabled. Each capture must land in one bit of one bank, raise the interrupt, and disappear cleanly after a write-one clear. This separates bank-index faults from bit-index faults. Writes that should be ignored are then applied and checked at the status words and the interrupt line: data past the last vector, addresses that differ in only the low half or only the high half, and a vector whose enable bit was just cleared by read-modify-write. Finally, collision cycles pair a capture with a clear of the same bit and of a different bit, and mask patterns show the status bits are still recorded while the interrupt line is held low.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_AW       = 12;
  localparam int REG_DW       = 32;
  localparam int BANK_W       = 32;
  localparam int TGT_LO_OFF   = 'h820;
  localparam int TGT_HI_OFF   = 'h824;
  localparam int BANK_BASE    = 'h828;
  localparam int BANK_STRIDE  = 12;
  localparam int ENA_SUB      = 0;
  localparam int MSK_SUB      = 4;
  localparam int STA_SUB      = 8;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic [REG_AW-1:0]    addr_i,
  output logic                 sel_tlo_o,
  output logic                 sel_thi_o,
  output logic [NUM_BANKS-1:0] sel_ena_o,
  output logic [NUM_BANKS-1:0] sel_msk_o,
  output logic [NUM_BANKS-1:0] sel_sta_o
);
  assign sel_tlo_o = (addr_i == REG_AW'(TGT_LO_OFF));
  assign sel_thi_o = (addr_i == REG_AW'(TGT_HI_OFF));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_sel
    localparam int GRP = BANK_BASE + BANK_STRIDE * b;
    assign sel_ena_o[b] = (addr_i == REG_AW'(GRP + ENA_SUB));
    assign sel_msk_o[b] = (addr_i == REG_AW'(GRP + MSK_SUB));
    assign sel_sta_o[b] = (addr_i == REG_AW'(GRP + STA_SUB));
  end
endmodule

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  localparam int NVEC     = NUM_BANKS * 32,
  localparam int VEC_W    = $clog2(NVEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [NVEC-1:0]   set_vec_o
);
  logic addr_hit;
  logic in_range;
  logic take;

  assign addr_hit = (addr_i == target_i);
  assign in_range = (data_i < DATA_W'(NVEC));
  assign take     = accept_i && addr_hit && in_range;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    assign set_vec_o[v] = take && (data_i[VEC_W-1:0] == VEC_W'(v));
  end

  AST_IGNORE_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_i >= DATA_W'(NVEC)) |-> (set_vec_o == '0)); // R4
  AST_ONE_VECTOR_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec_o)); // R3
  AST_MISS_SETS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != target_i) |-> (set_vec_o == '0)); // R3
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ena_we_i,
  input  logic         msk_we_i,
  input  logic         sta_w1c_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] status_o,
  output logic         pend_o
);
  logic [W-1:0] enable_q, mask_q, status_q;
  logic [W-1:0] set_eff, clr_bits;

  assign set_eff  = set_i & enable_q;
  assign clr_bits = sta_w1c_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (ena_we_i) enable_q <= wdata_i;
      if (msk_we_i) mask_q   <= wdata_i;
      status_q <= (status_q & ~clr_bits) | set_eff;
    end
  end

  assign enable_o = enable_q;
  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign pend_o   = |(status_q & ~mask_q);

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~$past(status_q) & ~$past(enable_q)) == '0); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eff != '0) |=> ((status_q & $past(set_eff)) == $past(set_eff))); // R7
  AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sta_w1c_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int NVEC = NUM_BANKS * BANK_W;

  logic [ADDR_W-1:0]    target_q;
  logic [REG_DW-1:0]    rdata_q, rd_mux;
  logic                 sel_tlo, sel_thi;
  logic [NUM_BANKS-1:0] sel_ena, sel_msk, sel_sta;
  logic [NVEC-1:0]      set_vec;
  logic [NUM_BANKS-1:0] pend;
  logic [BANK_W-1:0]    ena_w [NUM_BANKS];
  logic [BANK_W-1:0]    msk_w [NUM_BANKS];
  logic [BANK_W-1:0]    sta_w [NUM_BANKS];
  logic                 any_status;

  assign in_ready = 1'b1;

  msi_reg_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i    (reg_addr),
    .sel_tlo_o (sel_tlo),
    .sel_thi_o (sel_thi),
    .sel_ena_o (sel_ena),
    .sel_msk_o (sel_msk),
    .sel_sta_o (sel_sta)
  );

  msi_addr_match #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (in_valid && in_ready),
    .addr_i    (in_addr),
    .data_i    (in_data),
    .target_i  (target_q),
    .set_vec_o (set_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msi_bank #(.W(BANK_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ena_we_i  (reg_wr_en && sel_ena[b]),
      .msk_we_i  (reg_wr_en && sel_msk[b]),
      .sta_w1c_i (reg_wr_en && sel_sta[b]),
      .wdata_i   (reg_wdata),
      .set_i     (set_vec[b*BANK_W +: BANK_W]),
      .enable_o  (ena_w[b]),
      .mask_o    (msk_w[b]),
      .status_o  (sta_w[b]),
      .pend_o    (pend[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= '0;
    end else if (reg_wr_en) begin
      if (sel_tlo) target_q[31:0]       <= reg_wdata;
      if (sel_thi) target_q[ADDR_W-1:32] <= reg_wdata[ADDR_W-33:0];
    end
  end

  always_comb begin
    rd_mux     = '0;
    any_status = 1'b0;
    if (sel_tlo) rd_mux = rd_mux | target_q[31:0];
    if (sel_thi) rd_mux = rd_mux | REG_DW'(target_q[ADDR_W-1:32]);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_ena[b]) rd_mux = rd_mux | ena_w[b];
      if (sel_msk[b]) rd_mux = rd_mux | msk_w[b];
      if (sel_sta[b]) rd_mux = rd_mux | sta_w[b];
      any_status = any_status | (|sta_w[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata_q <= '0;
    else if (reg_rd_en) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = |pend;

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> any_status); // R8
  AST_TARGET_LO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_AW'(TGT_LO_OFF)) |=> (target_q[31:0] == $past(reg_wdata))); // R2
  AST_READY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready); // R9
endmodule

// File: tb/msi_capture_ctrl_test.sv
module msi_capture_ctrl_test;
  localparam int NB = 8;
  localparam logic [63:0] TGT = 64'h0000_0012_FEE0_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  msi_capture_ctrl #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [11:0] ena_a(int b); return 12'(12'h828 + 12 * b); endfunction
  function automatic logic [11:0] msk_a(int b); return 12'(12'h82C + 12 * b); endfunction
  function automatic logic [11:0] sta_a(int b); return 12'(12'h830 + 12 * b); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic msi_and_wr(input logic [31:0] v, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = TGT; in_data = v;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); in_valid = 1'b0; reg_wr_en = 1'b0;
  endtask

  task automatic all_status_zero(input string req);
    for (int b = 0; b < NB; b++) begin
      rd(sta_a(b), rv); chk(req, rv, 32'h0);
    end
    chk(req, 32'(irq_out), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_out), 32'h0);
    rd(12'h820, rv); chk("R1 tgt lo", rv, 32'h0);
    rd(12'h824, rv); chk("R1 tgt hi", rv, 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(ena_a(b), rv); chk("R1 enable", rv, 32'h0);
      rd(msk_a(b), rv); chk("R1 mask", rv, 32'h0);
      rd(sta_a(b), rv); chk("R1 status", rv, 32'h0);
    end

    // R2 target programming
    wr(12'h820, TGT[31:0]);
    wr(12'h824, TGT[63:32]);
    rd(12'h820, rv); chk("R2 tgt lo", rv, TGT[31:0]);
    rd(12'h824, rv); chk("R2 tgt hi", rv, TGT[63:32]);

    // R3 disabled vector is ignored
    msi(TGT, 32'd5);
    rd(sta_a(0), rv); chk("R3 disabled", rv, 32'h0);
    chk("R3 disabled irq", 32'(irq_out), 32'h0);

    // R5 enable all banks, check layout by distinct patterns
    for (int b = 0; b < NB; b++) wr(msk_a(b), 32'hA5A5_0000 | 32'(b));
    for (int b = 0; b < NB; b++) begin
      rd(msk_a(b), rv); chk("R5 mask layout", rv, 32'hA5A5_0000 | 32'(b));
      wr(msk_a(b), 32'h0);
      wr(ena_a(b), 32'hFFFF_FFFF);
      rd(ena_a(b), rv); chk("R5 enable layout", rv, 32'hFFFF_FFFF);
    end

    // R3/R6/R8 sweep over every vector
    for (int v = 0; v < NB * 32; v++) begin
      msi(TGT, 32'(v));
      chk("R8 irq raise", 32'(irq_out), 32'h1);
      rd(sta_a(v / 32), rv); chk("R3 sweep", rv, 32'h1 << (v % 32));
      wr(sta_a(v / 32), 32'h1 << (v % 32));
      chk("R8 irq drop", 32'(irq_out), 32'h0);
      rd(sta_a(v / 32), rv); chk("R6 sweep clear", rv, 32'h0);
    end

    // R4 out-of-range data
    msi(TGT, 32'(NB * 32));
    msi(TGT, 32'hFFFF_FFFF);
    msi(TGT, 32'h0000_0100 | 32'h1_0000);
    all_status_zero("R4 out of range");

    // R3 address mismatch in low or high half
    msi(TGT ^ 64'h4, 32'd3);
    msi(TGT ^ 64'h1_0000_0000, 32'd3);
    all_status_zero("R3 addr miss");

    // R6 clears only the written bits
    msi(TGT, 32'd3);
    msi(TGT, 32'd7);
    rd(sta_a(0), rv); chk("R6 two set", rv, 32'h88);
    wr(sta_a(0), 32'h8);
    rd(sta_a(0), rv); chk("R6 partial clear", rv, 32'h80);
    wr(sta_a(1), 32'hFFFF_FFFF);
    rd(sta_a(0), rv); chk("R6 other bank untouched", rv, 32'h80);

    // R7 set and clear of the same bit in one cycle
    msi_and_wr(32'd7, sta_a(0), 32'h80);
    rd(sta_a(0), rv); chk("R7 set wins", rv, 32'h80);
    msi_and_wr(32'd9, sta_a(0), 32'h80);
    rd(sta_a(0), rv); chk("R7 different bits", rv, 32'h200);

    // R8/R10 masking
    wr(msk_a(0), 32'hFFFF_FFFF);
    chk("R8 masked irq", 32'(irq_out), 32'h0);
    msi(TGT, 32'd40);
    chk("R8 other bank irq", 32'(irq_out), 32'h1);
    wr(msk_a(1), 32'h100);
    chk("R8 masked bit irq", 32'(irq_out), 32'h0);
    rd(sta_a(1), rv); chk("R10 masked still recorded", rv, 32'h100);
    msi(TGT, 32'd12);
    rd(sta_a(0), rv); chk("R10 capture while masked", rv, 32'h1200);
    chk("R10 irq stays low", 32'(irq_out), 32'h0);
    wr(msk_a(0), 32'hFFFF_EFFF);
    chk("R8 unmask one bit", 32'(irq_out), 32'h1);
    wr(sta_a(0), 32'hFFFF_FFFF);
    wr(sta_a(1), 32'hFFFF_FFFF);
    wr(msk_a(0), 32'h0);
    wr(msk_a(1), 32'h0);

    // R5 unmapped offsets
    rd(12'h000, rv); chk("R5 unmapped low", rv, 32'h0);
    rd(12'(12'h828 + 12 * NB), rv); chk("R5 past last bank", rv, 32'h0);
    rd(12'h822, rv); chk("R5 misaligned", rv, 32'h0);

    // R9 back-to-back accepts
    chk("R9 ready", 32'(in_ready), 32'h1);
    @(negedge clk); in_valid = 1'b1; in_addr = TGT; in_data = 32'd64;
    @(negedge clk); in_data = 32'd65;
    @(negedge clk); in_data = 32'd66;
    @(negedge clk); in_valid = 1'b0;
    rd(sta_a(2), rv); chk("R9 back to back", rv, 32'h7);
    wr(sta_a(2), 32'h7);

    // R3 read-modify-write disable of a single vector
    rd(ena_a(3), rv);
    wr(ena_a(3), rv & ~32'h4);
    rd(ena_a(3), rv); chk("R3 rmw enable", rv, 32'hFFFF_FFFB);
    msi(TGT, 32'd98);
    msi(TGT, 32'd99);
    rd(sta_a(3), rv); chk("R3 disabled bit skipped", rv, 32'h8);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule